// File: doc/BRIEF.md
# Pointer-Indexed Buffer Access Port

A host controller reaches a 2048-byte internal packet buffer without mapping it into its own address space. It sets up an 11-bit address pointer through two byte-wide registers and then streams bytes through one data register. Writing the high pointer byte stores the control bits and address bits 10:8 without loading them. Writing the low byte loads the full address into the active pointer. In read mode, that load also starts a fetch of the addressed byte into a holding register. With auto-increment enabled, the pointer advances after each data transfer and, when reading, the next byte is fetched ahead of time.

Host data cycles never wait. Reads return whatever the holding register contains. Writes are staged in the holding register and committed to the buffer later. A network-side requester shares the buffer through a fixed-priority arbiter that always serves the network side first. The arbitration slots occur on every clock, or on every second clock when a setup bit selects half rate. The flag `hold_valid_o` tells the host when it may make its next data access. After a burst, the host reads the pointer back to learn how many transfers completed.

Top module: `pbuf_port`

## Requirements
- R1: After reset, the active pointer is 0x000, `hold_valid_o` is 0, `net_gnt_o` is 0, and the registers at offsets 2, 3, 4 and 5 read as 0x00.
- R2: A write to offset 2 (the pointer high byte) does not change the active pointer. The register's bits take these meanings: bit 7 enables auto-increment, bit 6 selects the direction (1 = read, 0 = write), and bits 2:0 carry address bits 10:8. Reading offset 2 returns stored bits 7:3 together with bits 10:8 of the active pointer. Reading offset 3 returns pointer bits 7:0.
- R3: A write to offset 3 loads the pointer with {high byte bits 2:0, written byte}. In read mode the load starts a prefetch. With full-rate slots and an idle network side, `hold_valid_o` is 0 on the first clock after the load and 1 on the second. Offset 4 then reads the buffer byte at the pointer.
- R4: In read mode with auto-increment, a read of offset 4 while `hold_valid_o` is 1 returns the held byte, advances the pointer by one and prefetches the next byte. After n reads, the pointer reads back as start + n.
- R5: In read mode without auto-increment, repeated reads of offset 4 return the same byte. The pointer and `hold_valid_o` stay unchanged.
- R6: In write mode, a write to offset 4 stages the byte and sets `hold_valid_o` on the next clock. On the following arbitration slot, the byte is committed to the buffer at the pointer value it was written to, and `hold_valid_o` clears. With auto-increment enabled, the pointer advances by one per write.
- R7: Auto-increment wraps the pointer from 0x7FF to 0x000.
- R8: A write to offset 4 in read mode is ignored. The pointer, the held byte and the buffer contents do not change.
- R9: While `net_req_i` is 1, every arbitration slot goes to the network side and a pending host access waits. The host access completes on the first slot after the request drops.
- R10: Offset 5 bit 0 is readable. When it is 1, arbitration slots occur on every second clock, so a held network request is granted on alternate clocks. When it is 0, a slot occurs on every clock.
- R11: A network access happens in the clock where `net_gnt_o` is 1. It writes `net_wdata_i` when `net_we_i` is 1, and for a read, `net_rdata_o` carries the byte on the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_cs_i | input | 1 | Host register select |
| host_wr_i | input | 1 | Host write strobe, one clock |
| host_rd_i | input | 1 | Host read strobe, one clock |
| host_addr_i | input | 3 | Register offset |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Register read data, combinational |
| hold_valid_o | output | 1 | Holding register contains an unconsumed or uncommitted byte |
| net_req_i | input | 1 | Network-side access request |
| net_we_i | input | 1 | Network-side write enable |
| net_addr_i | input | 11 | Network-side buffer address |
| net_wdata_i | input | 8 | Network-side write data |
| net_gnt_o | output | 1 | Network access performed this clock |
| net_rdata_o | output | 8 | Network read data, valid the clock after a grant |

## Verification
The hardest situation to reach from the ports is a host prefetch that is starved by network traffic. The bench holds `net_req_i` high across a pointer load and then for several clocks. It checks that a grant is given on every clock and that `hold_valid_o` stays low throughout. It then drops the request and expects the stalled byte to arrive. The half-rate slot pattern is exposed in a similar way: a permanent network request makes the slot spacing visible on `net_gnt_o`.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  localparam int unsigned REG_AW = 3;
  localparam logic [REG_AW-1:0] OFS_PHI = 3'h2;
  localparam logic [REG_AW-1:0] OFS_PLO = 3'h3;
  localparam logic [REG_AW-1:0] OFS_DAT = 3'h4;
  localparam logic [REG_AW-1:0] OFS_SET = 3'h5;
  localparam int unsigned AUTO_BIT = 7;
  localparam int unsigned DIR_BIT  = 6;
endpackage

// File: rtl/pbuf_tick.sv
module pbuf_tick (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic tick_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  assign tick_o = ~slow_i | phase_q;
endmodule

// File: rtl/pbuf_arb.sv
module pbuf_arb (
  input  logic tick_i,
  input  logic net_req_i,
  input  logic host_req_i,
  output logic net_gnt_o,
  output logic host_gnt_o
);
  // network side has fixed priority
  assign net_gnt_o  = tick_i & net_req_i;
  assign host_gnt_o = tick_i & host_req_i & ~net_req_i;
endmodule

// File: rtl/pbuf_ram.sv
module pbuf_ram #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) mem[addr_i] <= d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= mem[addr_i];
  end
endmodule

// File: rtl/pbuf_regs.sv
module pbuf_regs
  import pbuf_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_cs_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [REG_AW-1:0] host_addr_i,
  input  logic [DW-1:0]     host_wdata_i,
  output logic [DW-1:0]     host_rdata_o,
  output logic              slow_o,
  output logic              req_o,
  output logic              we_o,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     wdata_o,
  input  logic              gnt_i,
  input  logic [DW-1:0]     ram_q_i,
  output logic [AW-1:0]     ptr_o,
  output logic              rd_valid_o,
  output logic              rd_inflight_o,
  output logic              wb_pend_o
);
  localparam int unsigned HI_W = AW - DW;
  localparam logic [AW-1:0] PTR_ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [DW-1:0] hi_q, hold_q;
  logic [AW-1:0] ptr_q, wb_addr_q;
  logic          slow_q, rd_pend_q, rd_infl_q, rd_valid_q, wb_pend_q;

  logic sel_wr, sel_rd, wr_hi, wr_lo, wr_set, rd_mode, auto_inc;
  logic dat_read, dat_write, serve_rd, serve_wb;

  assign sel_wr    = host_cs_i & host_wr_i;
  assign sel_rd    = host_cs_i & host_rd_i;
  assign wr_hi     = sel_wr & (host_addr_i == OFS_PHI);
  assign wr_lo     = sel_wr & (host_addr_i == OFS_PLO);
  assign wr_set    = sel_wr & (host_addr_i == OFS_SET);
  assign rd_mode   = hi_q[DIR_BIT];
  assign auto_inc  = hi_q[AUTO_BIT];
  assign dat_read  = sel_rd & (host_addr_i == OFS_DAT) & rd_mode & rd_valid_q;
  assign dat_write = sel_wr & (host_addr_i == OFS_DAT) & ~rd_mode;
  // write-back is served before a prefetch
  assign serve_wb  = gnt_i & wb_pend_q;
  assign serve_rd  = gnt_i & ~wb_pend_q & rd_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q       <= '0;
      slow_q     <= 1'b0;
      ptr_q      <= '0;
      wb_addr_q  <= '0;
      hold_q     <= '0;
      rd_pend_q  <= 1'b0;
      rd_infl_q  <= 1'b0;
      rd_valid_q <= 1'b0;
      wb_pend_q  <= 1'b0;
    end else begin
      if (wr_hi)  hi_q   <= host_wdata_i;
      if (wr_set) slow_q <= host_wdata_i[0];

      if (wr_lo)                                 ptr_q <= {hi_q[HI_W-1:0], host_wdata_i};
      else if ((dat_read | dat_write) & auto_inc) ptr_q <= ptr_q + PTR_ONE;

      if (wr_lo)                    rd_pend_q <= rd_mode;
      else if (dat_read & auto_inc) rd_pend_q <= 1'b1;
      else if (serve_rd)            rd_pend_q <= 1'b0;

      // a new pointer load discards any fetch still in flight
      rd_infl_q <= serve_rd & ~wr_lo;

      if (wr_lo)                    rd_valid_q <= 1'b0;
      else if (rd_infl_q)           rd_valid_q <= 1'b1;
      else if (dat_read & auto_inc) rd_valid_q <= 1'b0;

      if (rd_infl_q & ~wr_lo) hold_q <= ram_q_i;
      else if (dat_write)     hold_q <= host_wdata_i;

      if (dat_write)     wb_pend_q <= 1'b1;
      else if (serve_wb) wb_pend_q <= 1'b0;

      if (dat_write) wb_addr_q <= ptr_q;
    end
  end

  always_comb begin
    unique case (host_addr_i)
      OFS_PHI: host_rdata_o = {hi_q[DW-1:HI_W], ptr_q[AW-1:DW]};
      OFS_PLO: host_rdata_o = ptr_q[DW-1:0];
      OFS_DAT: host_rdata_o = hold_q;
      OFS_SET: host_rdata_o = {{(DW-1){1'b0}}, slow_q};
      default: host_rdata_o = '0;
    endcase
  end

  assign slow_o        = slow_q;
  assign req_o         = wb_pend_q | rd_pend_q;
  assign we_o          = wb_pend_q;
  assign addr_o        = wb_pend_q ? wb_addr_q : ptr_q;
  assign wdata_o       = hold_q;
  assign ptr_o         = ptr_q;
  assign rd_valid_o    = rd_valid_q;
  assign rd_inflight_o = rd_infl_q;
  assign wb_pend_o     = wb_pend_q;
endmodule

// File: rtl/pbuf_port.sv
module pbuf_port
  import pbuf_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_cs_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [REG_AW-1:0] host_addr_i,
  input  logic [DW-1:0]     host_wdata_i,
  output logic [DW-1:0]     host_rdata_o,
  output logic              hold_valid_o,
  input  logic              net_req_i,
  input  logic              net_we_i,
  input  logic [AW-1:0]     net_addr_i,
  input  logic [DW-1:0]     net_wdata_i,
  output logic              net_gnt_o,
  output logic [DW-1:0]     net_rdata_o
);
  logic          slow, tick, host_req, host_we, host_gnt;
  logic [AW-1:0] host_addr, ptr;
  logic [DW-1:0] host_wdata, ram_q, ram_d;
  logic          rd_valid, rd_inflight, wb_pend;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;

  pbuf_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .host_cs_i, .host_wr_i, .host_rd_i, .host_addr_i,
    .host_wdata_i, .host_rdata_o,
    .slow_o(slow), .req_o(host_req), .we_o(host_we), .addr_o(host_addr),
    .wdata_o(host_wdata), .gnt_i(host_gnt), .ram_q_i(ram_q),
    .ptr_o(ptr), .rd_valid_o(rd_valid), .rd_inflight_o(rd_inflight),
    .wb_pend_o(wb_pend)
  );

  pbuf_tick u_tick (.clk_i, .rst_ni, .slow_i(slow), .tick_o(tick));

  pbuf_arb u_arb (
    .tick_i(tick), .net_req_i, .host_req_i(host_req),
    .net_gnt_o, .host_gnt_o(host_gnt)
  );

  assign ram_en   = net_gnt_o | host_gnt;
  assign ram_we   = net_gnt_o ? net_we_i    : host_we;
  assign ram_addr = net_gnt_o ? net_addr_i  : host_addr;
  assign ram_d    = net_gnt_o ? net_wdata_i : host_wdata;

  pbuf_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk_i, .rst_ni, .en_i(ram_en), .we_i(ram_we), .addr_i(ram_addr),
    .d_i(ram_d), .q_o(ram_q)
  );

  assign hold_valid_o = rd_valid | wb_pend;
  assign net_rdata_o  = ram_q;
endmodule

// File: rtl/pbuf_port_chk.sv
module pbuf_port_chk #(
  parameter int unsigned AW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          net_req_i,
  input logic          net_gnt_o,
  input logic          host_gnt,
  input logic          tick,
  input logic          slow,
  input logic          rd_valid,
  input logic          rd_inflight,
  input logic          wb_pend,
  input logic          ram_en,
  input logic          ram_we,
  input logic [AW-1:0] ptr
);
  assert_net_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_gnt |-> !net_req_i);

  assert_one_owner_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({net_gnt_o, host_gnt}));

  assert_half_rate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow && tick) |=> (!tick || !slow));

  assert_prefetch_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid) |-> $past(rd_inflight));

  assert_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wb_pend) |-> $past(ram_en && ram_we));

  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ptr) == {AW{1'b1}} && ptr != {AW{1'b1}} && $past(rd_valid) && !rd_valid)
      |-> (ptr == '0));
endmodule

bind pbuf_port pbuf_port_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .net_req_i(net_req_i), .net_gnt_o(net_gnt_o),
  .host_gnt(host_gnt), .tick(tick), .slow(slow), .rd_valid(rd_valid),
  .rd_inflight(rd_inflight), .wb_pend(wb_pend), .ram_en(ram_en),
  .ram_we(ram_we), .ptr(ptr)
);

// File: tb/pbuf_port_bench.sv
module pbuf_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 0, wr = 0, rd = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       hold_valid;
  logic       net_req = 0, net_we = 0;
  logic [10:0] net_addr = 0;
  logic [7:0] net_wdata = 0;
  logic       net_gnt;
  logic [7:0] net_rdata;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbuf_port u_pbuf_port (
    .clk_i(clk), .rst_ni(rst_n), .host_cs_i(cs), .host_wr_i(wr), .host_rd_i(rd),
    .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .hold_valid_o(hold_valid), .net_req_i(net_req), .net_we_i(net_we),
    .net_addr_i(net_addr), .net_wdata_i(net_wdata), .net_gnt_o(net_gnt),
    .net_rdata_o(net_rdata)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a; #1 d = rdata;
    @(posedge clk); @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    cs = 0; addr = a; #1 d = rdata;
  endtask

  task automatic wait_valid(input logic lvl, input string tag);
    int n = 0;
    #1;
    while (hold_valid !== lvl && n < 50) begin @(negedge clk); #1; n++; end
    check(tag, {15'b0, hold_valid}, {15'b0, lvl});
  endtask

  task automatic net_access(input logic we, input logic [10:0] a,
                            input logic [7:0] d, output logic [7:0] q);
    int n = 0;
    @(negedge clk); net_req = 1; net_we = we; net_addr = a; net_wdata = d; #1;
    while (!net_gnt && n < 10) begin @(negedge clk); #1; n++; end
    @(posedge clk); @(negedge clk); net_req = 0; net_we = 0; #1 q = net_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 hold_valid", {15'b0, hold_valid}, 16'h0);
    check("R1 net_gnt", {15'b0, net_gnt}, 16'h0);
    for (int a = 2; a <= 5; a++) begin
      peek(a[2:0], d); check("R1 reg", {8'h0, d}, 16'h0);
    end
  endtask

  task automatic t_net;
    logic [7:0] q;
    for (int i = 0; i < 8; i++) net_access(1, 11'h100 + i[10:0], 8'h30 + i[7:0], q);
    net_access(1, 11'h7FE, 8'hAE, q);
    net_access(1, 11'h7FF, 8'hAF, q);
    net_access(1, 11'h000, 8'hC0, q);
    net_access(0, 11'h101, 8'h00, q);
    check("R11 net readback", {8'h0, q}, 16'h0031);
    net_access(0, 11'h7FF, 8'h00, q);
    check("R11 net readback top", {8'h0, q}, 16'h00AF);
  endtask

  task automatic t_load_burst;
    logic [7:0] d;
    host_wr(3'h2, 8'hC1);
    peek(3'h2, d); check("R2 high not loaded", {8'h0, d}, 16'h00C0);
    peek(3'h3, d); check("R2 low unchanged", {8'h0, d}, 16'h0000);
    host_wr(3'h3, 8'h00);
    #1 check("R3 valid after load", {15'b0, hold_valid}, 16'h0);
    @(negedge clk); #1 check("R3 valid clk1", {15'b0, hold_valid}, 16'h0);
    @(negedge clk); #1 check("R3 valid clk2", {15'b0, hold_valid}, 16'h1);
    peek(3'h2, d); check("R3 ptr high", {8'h0, d}, 16'h00C1);
    for (int i = 0; i < 4; i++) begin
      wait_valid(1, "R4 valid");
      host_rd(3'h4, d);
      check("R4 burst data", {8'h0, d}, 16'h0030 + i[15:0]);
    end
    peek(3'h3, d); check("R4 ptr count", {8'h0, d}, 16'h0004);
  endtask

  task automatic t_noinc_ignore;
    logic [7:0] d, q;
    host_wr(3'h2, 8'h41);
    host_wr(3'h3, 8'h05);
    wait_valid(1, "R5 valid");
    for (int i = 0; i < 3; i++) begin
      host_rd(3'h4, d); check("R5 same byte", {8'h0, d}, 16'h0035);
    end
    peek(3'h3, d); check("R5 ptr held", {8'h0, d}, 16'h0005);
    check("R5 valid held", {15'b0, hold_valid}, 16'h1);
    host_wr(3'h4, 8'hEE);
    repeat (3) @(negedge clk);
    peek(3'h3, d); check("R8 ptr", {8'h0, d}, 16'h0005);
    peek(3'h4, d); check("R8 hold", {8'h0, d}, 16'h0035);
    net_access(0, 11'h105, 8'h00, q);
    check("R8 ram", {8'h0, q}, 16'h0035);
  endtask

  task automatic t_write;
    logic [7:0] d, q;
    host_wr(3'h2, 8'h82);
    host_wr(3'h3, 8'h10);
    host_wr(3'h4, 8'h5A);
    #1 check("R6 staged", {15'b0, hold_valid}, 16'h1);
    @(negedge clk); #1 check("R6 committed", {15'b0, hold_valid}, 16'h0);
    host_wr(3'h4, 8'h5B);
    wait_valid(0, "R6 commit2");
    peek(3'h3, d); check("R6 ptr", {8'h0, d}, 16'h0012);
    net_access(0, 11'h210, 8'h00, q); check("R6 ram0", {8'h0, q}, 16'h005A);
    net_access(0, 11'h211, 8'h00, q); check("R6 ram1", {8'h0, q}, 16'h005B);
  endtask

  task automatic t_wrap;
    logic [7:0] d;
    host_wr(3'h2, 8'hC7);
    host_wr(3'h3, 8'hFE);
    wait_valid(1, "R7 v0"); host_rd(3'h4, d); check("R7 d0", {8'h0, d}, 16'h00AE);
    wait_valid(1, "R7 v1"); host_rd(3'h4, d); check("R7 d1", {8'h0, d}, 16'h00AF);
    wait_valid(1, "R7 v2"); host_rd(3'h4, d); check("R7 d2", {8'h0, d}, 16'h00C0);
    peek(3'h2, d); check("R7 ptr high", {8'h0, d}, 16'h00C0);
    peek(3'h3, d); check("R7 ptr low", {8'h0, d}, 16'h0001);
  endtask

  task automatic t_priority;
    logic [7:0] d;
    int g = 0;
    @(negedge clk); net_req = 1; net_we = 0; net_addr = 11'h000;
    host_wr(3'h2, 8'hC1);
    host_wr(3'h3, 8'h00);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      if (net_gnt) g++;
      check("R9 host starved", {15'b0, hold_valid}, 16'h0);
    end
    check("R9 net grants", g[15:0], 16'd6);
    net_req = 0;
    @(negedge clk); #1 check("R9 still waiting", {15'b0, hold_valid}, 16'h0);
    @(negedge clk); #1 check("R9 served", {15'b0, hold_valid}, 16'h1);
    peek(3'h4, d); check("R9 data", {8'h0, d}, 16'h0030);
  endtask

  task automatic t_slow;
    logic [7:0] d;
    int g = 0;
    logic prev = 0;
    int dbl = 0;
    host_wr(3'h5, 8'h01);
    peek(3'h5, d); check("R10 setup readback", {8'h0, d}, 16'h0001);
    @(negedge clk); net_req = 1; net_we = 0; net_addr = 11'h000;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      if (net_gnt) g++;
      if (net_gnt && prev) dbl++;
      prev = net_gnt;
    end
    net_req = 0;
    check("R10 half grants", g[15:0], 16'd4);
    check("R10 no adjacent", dbl[15:0], 16'd0);
    host_wr(3'h2, 8'hC1);
    host_wr(3'h3, 8'h03);
    wait_valid(1, "R10 prefetch slow");
    peek(3'h4, d); check("R10 slow data", {8'h0, d}, 16'h0033);
    host_wr(3'h5, 8'h00);
    g = 0;
    @(negedge clk); net_req = 1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); #1; if (net_gnt) g++; end
    net_req = 0;
    check("R10 full grants", g[15:0], 16'd4);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_net();
    t_load_burst();
    t_noinc_ignore();
    t_write();
    t_wrap();
    t_priority();
    t_slow();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule